// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

A periodic tick source for a processor subsystem. A 24-bit counter steps down by one on every selected clock tick. When it has reached zero, the next step loads it from a software-set reload value. This gives a repeating period of reload-plus-one steps. Each time the counter arrives at zero, a sticky status flag is set and, if enabled, a single-cycle interrupt pulse is issued. The source of the steps is chosen by a control bit: every core clock cycle, or only those cycles where an external reference strobe is high.

Software uses three word registers on a plain single-cycle register port. One register holds the control bits and the status flag. One holds the reload value. One gives the live count. Read data is combinational in the cycle of the request. Register side effects (write updates, clear-on-read) take effect at the clock edge that ends that cycle. Byte offsets: 0x0 control/status, 0x4 reload, 0x8 current value, 0xC unused. The register port has no back-pressure: every request completes in its own cycle.

Top module: `downtick_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `tick_irq` is low.
- R2: While running, the count drops by one per step. A step taken at zero loads the reload value, so a reload of N-1 gives one arrival at zero every N steps (reload 1 gives 2 steps, reload 4 gives 5).
- R3: A write of any data to the current-value register (offset 0x8) sets the count to zero and clears the status flag. It wins over a step in the same cycle: that step neither counts nor sets the flag nor pulses the interrupt.
- R4: Reading control/status (offset 0x0) returns the status flag in bit 16 and clears it. If the flag is being set in that same cycle, the set wins.
- R5: Control bit 0 runs the counter, bit 1 enables the interrupt, bit 2 selects the step source (1 = every core clock cycle, 0 = only cycles with `ref_tick` high). All other control bits read zero, and bit 16 cannot be written.
- R6: Each arrival of the count at zero from one sets the flag. If bit 1 is set, it also drives `tick_irq` high for exactly one cycle, in the cycle the count first reads zero. With bit 1 clear there is no pulse, but the flag is still set.
- R7: With bit 0 clear, the count holds its value and no pulse occurs. Control writes keep exactly the written bits 0 to 2.
- R8: Reload and current value hold 24 bits; write bits 31:24 are dropped and read as zero.
- R9: With reload zero and the count at zero, the counter stays at zero, the flag is not set and no pulse occurs.
- R10: Offset 0xC reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference step strobe, used when control bit 2 is 0 |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| tick_irq | output | 1 | One-cycle interrupt pulse per arrival at zero |

## Verification
The period is measured as the cycle gap between interrupt pulses. This is done for reload values 4 and 1 with core-clock steps, and for reload 4 with a reference strobe every third cycle. These runs show that the counter reloads rather than stopping, and that it steps on the strobe and not on the clock. A hand-stepped run brings the count to one, then writes the current-value register in the very step that would reach zero. This separates write priority from counting. Runs with the interrupt disabled, with the counter disabled and with reload zero each show whether the flag and the pulse are tied to the right conditions.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
  // Register index, taken from byte offset bits [3:2]
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CURR   = 2'd2,
    REG_NONE   = 2'd3
  } tt_reg_e;

  // Control/status bit positions seen by software
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic src;  // 1: step every clock, 0: step on ref_tick
    logic ien;  // interrupt enable
    logic run;  // counter enable
  } tt_ctrl_t;
endpackage

// File: rtl/tt_bus_regs.sv
`timescale 1ns/1ps
module tt_bus_regs
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              flag,
  output tt_ctrl_t          ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr,
  output logic              ctrl_rd
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic    in_range;
  tt_reg_e sel;
  logic    wr_ctrl, wr_reload;
  logic    wdata_unused;

  // Offsets beyond the register window decode to nothing
  generate
    if (ADDR_W > 4) begin : g_wide_addr
      assign in_range = (bus_addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow_addr
      assign in_range = 1'b1;
    end
  endgenerate

  assign sel = in_range ? tt_reg_e'(bus_addr[3:2]) : REG_NONE;

  assign wr_ctrl   = bus_req &&  bus_we && (sel == REG_CTRL);
  assign wr_reload = bus_req &&  bus_we && (sel == REG_RELOAD);
  assign cur_wr    = bus_req &&  bus_we && (sel == REG_CURR);
  assign ctrl_rd   = bus_req && !bus_we && (sel == REG_CTRL);

  assign wdata_unused = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.run <= bus_wdata[BIT_RUN];
        ctrl.ien <= bus_wdata[BIT_IEN];
        ctrl.src <= bus_wdata[BIT_SRC];
      end
      if (wr_reload) begin
        reload <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      unique case (sel)
        REG_CTRL: begin
          bus_rdata[BIT_RUN]  = ctrl.run;
          bus_rdata[BIT_IEN]  = ctrl.ien;
          bus_rdata[BIT_SRC]  = ctrl.src;
          bus_rdata[BIT_FLAG] = flag;
        end
        REG_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload};
        REG_CURR:   bus_rdata = {{PAD_W{1'b0}}, cur_val};
        default:    bus_rdata = '0;
      endcase
    end
  end

  // Control bits only move on a control write
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl)) else $error("control changed without write"); // R7

  // Unmapped offset returns zero
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && sel == REG_NONE) |-> (bus_rdata == '0)) else $error("hole read nonzero"); // R10
endmodule

// File: rtl/tt_count_core.sv
`timescale 1ns/1ps
module tt_count_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src,
  input  logic             ref_tick,
  input  logic             cur_wr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur_val,
  output logic             hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step     = run && (src || ref_tick);
  // Arrival at zero: a real step from one, not overridden by a write
  assign hit_zero = step && !cur_wr && (cur_val == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_val <= '0;
    end else if (cur_wr) begin
      cur_val <= '0;
    end else if (step) begin
      if (cur_val == '0) cur_val <= reload;
      else               cur_val <= cur_val - ONE;
    end
  end

  AST_WRITE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur_val == '0)) else $error("current write did not zero"); // R3

  AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cur_wr && cur_val == '0) |=> (cur_val == $past(reload))) else $error("no reload at zero"); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cur_wr) |=> $stable(cur_val)) else $error("count moved while stopped"); // R7

  AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_val == '0 && reload == '0) |=> (cur_val == '0)) else $error("left zero with zero reload"); // R9
endmodule

// File: rtl/tt_wrap_flag.sv
`timescale 1ns/1ps
module tt_wrap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_zero,
  input  logic cur_wr,
  input  logic ctrl_rd,
  input  logic ien,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      // A fresh arrival beats any clearing access
      if (hit_zero)               flag <= 1'b1;
      else if (cur_wr || ctrl_rd) flag <= 1'b0;
      irq <= hit_zero && ien;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("interrupt wider than one cycle"); // R6

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag) else $error("interrupt without flag"); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !hit_zero) |=> !flag) else $error("flag survived read"); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero |=> flag) else $error("flag missed arrival"); // R4
endmodule

// File: rtl/downtick_timer.sv
`timescale 1ns/1ps
module downtick_timer
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  tt_ctrl_t         ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cur_val;
  logic             cur_wr, ctrl_rd, hit_zero, flag;

  tt_bus_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cur_val   (cur_val),
    .flag      (flag),
    .ctrl      (ctrl),
    .reload    (reload),
    .cur_wr    (cur_wr),
    .ctrl_rd   (ctrl_rd)
  );

  tt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .src      (ctrl.src),
    .ref_tick (ref_tick),
    .cur_wr   (cur_wr),
    .reload   (reload),
    .cur_val  (cur_val),
    .hit_zero (hit_zero)
  );

  tt_wrap_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_zero (hit_zero),
    .cur_wr   (cur_wr),
    .ctrl_rd  (ctrl_rd),
    .ien      (ctrl.ien),
    .flag     (flag),
    .irq      (tick_irq)
  );

  // Interrupt only after an enabled, counting cycle
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> ($past(ctrl.ien) && $past(ctrl.run))) else $error("ungated interrupt"); // R6

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (cur_val == '0)) else $error("interrupt with nonzero count"); // R6
endmodule

// File: tb/downtick_timer_tb_top.sv
`timescale 1ns/1ps
module downtick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit ref_auto = 1'b0, ref_force = 1'b0, ref_ph = 1'b0;
  int ref_div = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_HOLE = 4'hC;
  localparam int FLAG = 16;

  always #4 clk = ~clk;  // 125 MHz

  assign ref_tick = ref_auto ? ref_ph : ref_force;

  always @(negedge clk) begin
    ref_div = (ref_div == 2) ? 0 : ref_div + 1;
    ref_ph  = (ref_div == 0);
    if (tick_irq) irq_cnt++;
  end

  downtick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!tick_irq && n < 400) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic gap(output int g);
    int n;
    wait_irq(n);
    @(negedge clk);
    wait_irq(n);
    g = n + 1;
  endtask

  task automatic step_ref(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_force = 1'b1;
      @(negedge clk); ref_force = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl after reset", v, 0);
    rd(A_RLD, v);  check("R1 reload after reset", v, 0);
    rd(A_CUR, v);  check("R1 current after reset", v, 0);
    check("R1 irq after reset", {31'b0, tick_irq}, 0);
  endtask

  task automatic t_core_period();
    logic [31:0] v, w;
    int g;
    wr(A_RLD, 32'd4); wr(A_CUR, 32'd0); wr(A_CTRL, 32'h7);
    gap(g); check("R2 period reload 4", g, 5);
    @(negedge clk); check("R6 pulse one cycle", {31'b0, tick_irq}, 0);
    rd(A_CTRL, v); rd(A_CTRL, w);
    check("R4 flag read set", v, 32'h7 | (32'h1 << FLAG));
    check("R4 flag cleared by read", w, 32'h7);
    wr(A_RLD, 32'd1);
    gap(g); gap(g); check("R2 period reload 1", g, 2);
  endtask

  task automatic t_ref_period();
    logic [31:0] a, b;
    int g;
    wr(A_RLD, 32'd4); wr(A_CTRL, 32'h3);
    ref_auto = 1'b1;
    gap(g); gap(g); check("R5 ref strobe period", g, 15);
    ref_auto = 1'b0; ref_force = 1'b0;
    rd(A_CUR, a); repeat (10) @(negedge clk); rd(A_CUR, b);
    check("R5 no strobe no step", b, a);
  endtask

  task automatic t_no_ien();
    logic [31:0] v;
    wr(A_CTRL, 32'h5); rd(A_CTRL, v);
    irq_cnt = 0;
    repeat (12) @(negedge clk);
    check("R6 no pulse with ien clear", irq_cnt, 0);
    rd(A_CTRL, v); check("R6 flag set with ien clear", v, 32'h5 | (32'h1 << FLAG));
  endtask

  task automatic t_cur_write();
    logic [31:0] v;
    wr(A_CTRL, 32'h3); wr(A_RLD, 32'd4); wr(A_CUR, 32'd0);
    step_ref(5);  // 4,3,2,1,0 -> flag set
    wr(A_CUR, 32'hFFFF_FFFF);
    rd(A_CUR, v);  check("R3 write zeroes count", v, 0);
    rd(A_CTRL, v); check("R3 write clears flag", v, 32'h3);
    step_ref(4);  // 4,3,2,1
    rd(A_CUR, v);  check("R3 stepped to one", v, 1);
    irq_cnt = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_CUR; bus_wdata = 32'h00AB_CDEF; ref_force = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; ref_force = 1'b0;
    rd(A_CUR, v);  check("R3 write beats step count", v, 0);
    rd(A_CTRL, v); check("R3 write beats step flag", v, 32'h3);
    check("R3 write beats step irq", irq_cnt, 0);
  endtask

  task automatic t_disable();
    logic [31:0] a, b;
    wr(A_CTRL, 32'h7);
    repeat (7) @(negedge clk);
    wr(A_CTRL, 32'h6);
    irq_cnt = 0;
    rd(A_CUR, a); repeat (6) @(negedge clk); rd(A_CUR, b);
    check("R7 count frozen", b, a);
    check("R7 no pulse stopped", irq_cnt, 0);
    rd(A_CTRL, a); check("R7 other bits kept", a & 32'h7, 32'h6);
  endtask

  task automatic t_widths();
    logic [31:0] v;
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, v); check("R8 reload 24 bits", v, 32'h00FF_FFFF);
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, v); check("R5 unused ctrl bits zero", v, 0);
  endtask

  task automatic t_zero_reload();
    logic [31:0] v;
    wr(A_RLD, 32'd0); wr(A_CUR, 32'd0); wr(A_CTRL, 32'h7);
    irq_cnt = 0;
    repeat (20) @(negedge clk);
    check("R9 no pulse", irq_cnt, 0);
    rd(A_CUR, v);  check("R9 stays zero", v, 0);
    rd(A_CTRL, v); check("R9 no flag", v, 32'h7);
  endtask

  task automatic t_hole();
    logic [31:0] v;
    wr(A_CTRL, 32'h0); wr(A_RLD, 32'h55);
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, v); check("R10 hole reads zero", v, 0);
    rd(A_RLD, v);  check("R10 reload untouched", v, 32'h55);
    rd(A_CTRL, v); check("R10 ctrl untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_core_period();
    t_ref_period();
    t_no_ien();
    t_cur_write();
    t_disable();
    t_widths();
    t_zero_reload();
    t_hole();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule